// File: doc/BRIEF.md
# Network-Mode Last-Slot Status Flags

This block gives status and interrupt information for the final time slot of a frame on a time-division-multiplexed serial port in network mode. The block has two independent channels, one for the transmit frame and one for the receive frame. Each channel compares the current slot index against its slots-per-frame setting. It qualifies that comparison with a slot-valid strobe and drives one status flag and one interrupt line.

Each channel has an interrupt enable, and the enable selects how the flag behaves. With the enable off, the flag is a live timing indicator. It is high only during a valid last slot, and software polls it to find the frame boundary. With the enable on, the flag is a sticky interrupt source. A last slot sets it, it stays set, and software clears it by writing a one to its bit in the status word. When network mode is off, the block forces all of its outputs low.

Every input is a plain control or status pin. The block carries no data stream, so it has no valid/ready handshake and applies no back-pressure.

Top module: `lsf_status_flags`

## Requirements
- R1: When the transmit interrupt enable is off and network mode is on, `tx_last_flag` is high in exactly the cycles where `tx_slot_vld` is high and `tx_slot_idx` equals `tx_slots_per_frame` minus 1. There is no added delay, and `tx_irq` stays low.
- R2: The receive channel behaves the same way as R1, using `rx_slot_vld`, `rx_slot_idx`, `rx_slots_per_frame`, `rx_last_flag` and `rx_irq`.
- R3: When a channel's interrupt enable is on, a qualified last slot sets that channel's flag from the next clock edge. The flag then stays high, including across cycles with no slot activity, until it is cleared.
- R4: A cycle with `stat_wr_en` high clears the transmit flag at the next edge if `stat_wr_data[11]` is 1, and clears the receive flag if `stat_wr_data[10]` is 1. A 0 in either bit, or any data while `stat_wr_en` is low, leaves the flags unchanged.
- R5: If a qualified last slot and a write-one clear reach the same channel in the same cycle, the flag is set after the edge.
- R6: A channel's interrupt output equals its flag while the channel's interrupt enable is on, and is 0 while the enable is off.
- R7: Turning a channel's interrupt enable off drops its flag to the live last-slot value in the same cycle. It also discards the latched state, so turning the enable back on does not bring the flag back.
- R8: While `net_mode` is low, all four outputs are 0 and any latched state is discarded.
- R9: A slots-per-frame value of 0 never produces a last slot. A value of 1 makes slot 0 the last slot.
- R10: After reset, all flags and interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| net_mode | input | 1 | Network mode on |
| tx_irq_en | input | 1 | Transmit last-slot interrupt enable |
| rx_irq_en | input | 1 | Receive last-slot interrupt enable |
| tx_slot_vld | input | 1 | Transmit slot index is valid this cycle |
| tx_slot_idx | input | SLOT_W | Current transmit slot index |
| tx_slots_per_frame | input | SLOT_W | Transmit slots per frame |
| rx_slot_vld | input | 1 | Receive slot index is valid this cycle |
| rx_slot_idx | input | SLOT_W | Current receive slot index |
| rx_slots_per_frame | input | SLOT_W | Receive slots per frame |
| stat_wr_en | input | 1 | Status word write strobe |
| stat_wr_data | input | STAT_W | Status write data: bit 11 clears transmit, bit 10 clears receive |
| tx_last_flag | output | 1 | Transmit last-slot flag |
| rx_last_flag | output | 1 | Receive last-slot flag |
| tx_irq | output | 1 | Transmit last-slot interrupt |
| rx_irq | output | 1 | Receive last-slot interrupt |

## Verification
The assertions assume the following about the inputs:
- The slot strobe, slot index, slots-per-frame, enables and write strobe are synchronous to `clk` and stable around each rising edge.
- Slots-per-frame does not change in the middle of a frame.

The stimulus keeps within these assumptions. It changes every input only on the falling edge and holds it for the whole cycle. It keeps slots-per-frame fixed throughout the vector table, and changes it only in directed steps where no latched state is in play. The set-wins and hold properties rely on the enable and network mode being stable across the edge they reason about, and the vectors change those inputs only between such edges.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  localparam int STAT_W     = 16;
  localparam int TX_STAT_BIT = 11;
  localparam int RX_STAT_BIT = 10;
  localparam int NUM_CH     = 2;
  localparam int CH_TX      = 0;
  localparam int CH_RX      = 1;

  typedef enum logic {
    MODE_LIVE  = 1'b0,
    MODE_LATCH = 1'b1
  } flag_mode_e;
endpackage

// File: rtl/lsf_last_detect.sv
module lsf_last_detect #(
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_vld,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [SLOT_W-1:0] slots_per_frame,
  output logic              last_hit
);
  localparam logic [SLOT_W-1:0] ONE = SLOT_W'(1);

  logic              spf_nonzero;
  logic [SLOT_W-1:0] last_idx;

  always_comb begin
    spf_nonzero = |slots_per_frame;
    last_idx    = slots_per_frame - ONE;
    last_hit    = slot_vld && spf_nonzero && (slot_idx == last_idx);
  end

  // R9: an empty frame has no last slot
  p_zero_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slots_per_frame == '0) |-> !last_hit);

  // R1: no detection without the valid strobe
  p_needs_vld_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_vld |-> !last_hit);
endmodule

// File: rtl/lsf_flag_cell.sv
module lsf_flag_cell
  import lsf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic net_mode,
  input  logic irq_en,
  input  logic last_hit,
  input  logic clr_req,
  output logic flag_o,
  output logic irq_o
);
  flag_mode_e mode;
  logic       held_q;
  logic       held_d;

  always_comb begin
    mode = irq_en ? MODE_LATCH : MODE_LIVE;
    if (!net_mode || mode == MODE_LIVE) begin
      held_d = 1'b0;
    end else begin
      held_d = last_hit || (held_q && !clr_req);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  always_comb begin
    flag_o = 1'b0;
    if (net_mode) begin
      unique case (mode)
        MODE_LATCH: flag_o = held_q;
        MODE_LIVE:  flag_o = last_hit;
        default:    flag_o = 1'b0;
      endcase
    end
    irq_o = flag_o && (mode == MODE_LATCH);
  end

  // R5: a set beats a simultaneous clear
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (net_mode && irq_en && last_hit) |=> held_q);

  // R4: a clear with no set empties the latch
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !last_hit) |=> !held_q);

  // R3: the latch holds while nothing clears it
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && net_mode && irq_en && !clr_req) |=> held_q);

  // R6: interrupt only with the enable on
  p_irq_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_en);

  // R8: outside network mode everything is low
  p_off_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !net_mode |-> (!flag_o && !irq_o));

  // R7: a disabled enable leaves no latched state behind
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !held_q);
endmodule

// File: rtl/lsf_status_flags.sv
module lsf_status_flags
  import lsf_pkg::*;
#(
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              net_mode,
  input  logic              tx_irq_en,
  input  logic              rx_irq_en,
  input  logic              tx_slot_vld,
  input  logic [SLOT_W-1:0] tx_slot_idx,
  input  logic [SLOT_W-1:0] tx_slots_per_frame,
  input  logic              rx_slot_vld,
  input  logic [SLOT_W-1:0] rx_slot_idx,
  input  logic [SLOT_W-1:0] rx_slots_per_frame,
  input  logic              stat_wr_en,
  input  logic [STAT_W-1:0] stat_wr_data,
  output logic              tx_last_flag,
  output logic              rx_last_flag,
  output logic              tx_irq,
  output logic              rx_irq
);
  logic [NUM_CH-1:0]             ch_vld;
  logic [NUM_CH-1:0][SLOT_W-1:0] ch_idx;
  logic [NUM_CH-1:0][SLOT_W-1:0] ch_spf;
  logic [NUM_CH-1:0]             ch_en;
  logic [NUM_CH-1:0]             ch_clr;
  logic [NUM_CH-1:0]             ch_hit;
  logic [NUM_CH-1:0]             ch_flag;
  logic [NUM_CH-1:0]             ch_irq;

  always_comb begin
    ch_vld[CH_TX] = tx_slot_vld;
    ch_vld[CH_RX] = rx_slot_vld;
    ch_idx[CH_TX] = tx_slot_idx;
    ch_idx[CH_RX] = rx_slot_idx;
    ch_spf[CH_TX] = tx_slots_per_frame;
    ch_spf[CH_RX] = rx_slots_per_frame;
    ch_en[CH_TX]  = tx_irq_en;
    ch_en[CH_RX]  = rx_irq_en;
    ch_clr[CH_TX] = stat_wr_en && stat_wr_data[TX_STAT_BIT];
    ch_clr[CH_RX] = stat_wr_en && stat_wr_data[RX_STAT_BIT];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    lsf_last_detect #(.SLOT_W(SLOT_W)) u_det (
      .clk             (clk),
      .rst_n           (rst_n),
      .slot_vld        (ch_vld[g]),
      .slot_idx        (ch_idx[g]),
      .slots_per_frame (ch_spf[g]),
      .last_hit        (ch_hit[g])
    );

    lsf_flag_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .net_mode (net_mode),
      .irq_en   (ch_en[g]),
      .last_hit (ch_hit[g]),
      .clr_req  (ch_clr[g]),
      .flag_o   (ch_flag[g]),
      .irq_o    (ch_irq[g])
    );
  end

  always_comb begin
    tx_last_flag = ch_flag[CH_TX];
    rx_last_flag = ch_flag[CH_RX];
    tx_irq       = ch_irq[CH_TX];
    rx_irq       = ch_irq[CH_RX];
  end

  // R10: quiet right after reset
  p_reset_quiet_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> (!tx_irq && !rx_irq));
endmodule

// File: tb/lsf_status_flags_bench.sv
module lsf_status_flags_bench;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          net_mode = 1'b0;
  logic          tx_irq_en = 1'b0, rx_irq_en = 1'b0;
  logic          tx_slot_vld = 1'b0, rx_slot_vld = 1'b0;
  logic [SW-1:0] tx_slot_idx = '0, rx_slot_idx = '0;
  logic [SW-1:0] tx_spf = 4'd4, rx_spf = 4'd3;
  logic          stat_wr_en = 1'b0;
  logic [15:0]   stat_wr_data = '0;
  logic          tx_last_flag, rx_last_flag, tx_irq, rx_irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lsf_status_flags #(.SLOT_W(SW)) u_lsf_status_flags (
    .clk(clk), .rst_n(rst_n), .net_mode(net_mode),
    .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en),
    .tx_slot_vld(tx_slot_vld), .tx_slot_idx(tx_slot_idx), .tx_slots_per_frame(tx_spf),
    .rx_slot_vld(rx_slot_vld), .rx_slot_idx(rx_slot_idx), .rx_slots_per_frame(rx_spf),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
    .tx_last_flag(tx_last_flag), .rx_last_flag(rx_last_flag),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  // {net, tx_en, rx_en, tx_vld, tx_idx, rx_vld, rx_idx, clr_tx, clr_rx, exp txf rxf txi rxi}
  // tx frame 4 slots (last = 3), rx frame 3 slots (last = 2); stat_wr_en is 1 on every row
  localparam int NV = 15;
  localparam logic [18:0] VEC [NV] = '{
    {3'b100, 1'b1, 4'd3, 1'b0, 4'd2, 2'b00, 4'b1000}, // R1 live tx
    {3'b100, 1'b1, 4'd2, 1'b1, 4'd2, 2'b00, 4'b0100}, // R2 live rx
    {3'b100, 1'b0, 4'd3, 1'b0, 4'd2, 2'b00, 4'b0000}, // R1 strobe qualifies
    {3'b111, 1'b1, 4'd3, 1'b0, 4'd0, 2'b00, 4'b0000}, // R3 set pending
    {3'b111, 1'b0, 4'd0, 1'b1, 4'd2, 2'b00, 4'b1010}, // R3 tx latched, R6
    {3'b111, 1'b0, 4'd0, 1'b0, 4'd0, 2'b00, 4'b1111}, // R3 hold, R4 zero write
    {3'b111, 1'b0, 4'd0, 1'b0, 4'd0, 2'b10, 4'b1111}, // R4 clear tx issued
    {3'b111, 1'b0, 4'd0, 1'b0, 4'd0, 2'b00, 4'b0101}, // R4 tx cleared
    {3'b111, 1'b1, 4'd3, 1'b0, 4'd0, 2'b10, 4'b0101}, // R5 set and clear
    {3'b111, 1'b0, 4'd0, 1'b0, 4'd0, 2'b00, 4'b1111}, // R5 set won
    {3'b101, 1'b0, 4'd0, 1'b0, 4'd0, 2'b00, 4'b0101}, // R7 tx enable off
    {3'b111, 1'b0, 4'd0, 1'b0, 4'd0, 2'b00, 4'b0101}, // R7 latch discarded
    {3'b011, 1'b1, 4'd3, 1'b1, 4'd2, 2'b00, 4'b0000}, // R8 net off
    {3'b111, 1'b0, 4'd0, 1'b0, 4'd0, 2'b00, 4'b0000}, // R8 latch discarded
    {3'b000, 1'b1, 4'd3, 1'b1, 4'd2, 2'b00, 4'b0000}  // R8 live off too
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs txf/rxf/txi/rxi actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {tx_last_flag, rx_last_flag, tx_irq, rx_irq};
  endfunction

  task automatic idle_cycle();
    @(negedge clk);
    tx_slot_vld = 1'b0; rx_slot_vld = 1'b0; stat_wr_en = 1'b0; stat_wr_data = '0;
  endtask

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1 check("R10 in reset", outs(), 4'b0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {net_mode, tx_irq_en, rx_irq_en, tx_slot_vld, tx_slot_idx,
       rx_slot_vld, rx_slot_idx} = VEC[i][18:4+2];
      stat_wr_en   = 1'b1;
      stat_wr_data = '0;
      stat_wr_data[11] = VEC[i][5];
      stat_wr_data[10] = VEC[i][4];
      #2 check($sformatf("vector %0d", i), outs(), VEC[i][3:0]);
    end

    // R4: write with strobe low is ignored; rx clear via bit 10
    idle_cycle();
    net_mode = 1'b1; tx_irq_en = 1'b1; rx_irq_en = 1'b1;
    tx_slot_vld = 1'b1; tx_slot_idx = 4'd3; rx_slot_vld = 1'b1; rx_slot_idx = 4'd2;
    idle_cycle();
    stat_wr_en = 1'b0; stat_wr_data = 16'h0C00;
    idle_cycle();
    #2 check("R4 write strobe low ignored", outs(), 4'b1111);
    stat_wr_en = 1'b1; stat_wr_data = 16'h0400;
    idle_cycle();
    #2 check("R4 rx cleared by bit 10", outs(), 4'b1010);

    // R10: reset clears latched state
    rst_n = 1'b0;
    #2 check("R10 reset clears latch", outs(), 4'b0000);
    idle_cycle();
    rst_n = 1'b1;
    idle_cycle();
    #2 check("R10 after reset", outs(), 4'b0000);

    // R9: zero-slot frame and one-slot frame, live mode
    tx_irq_en = 1'b0; rx_irq_en = 1'b0;
    tx_spf = 4'd0; tx_slot_vld = 1'b1; tx_slot_idx = 4'd15;
    rx_spf = 4'd1; rx_slot_vld = 1'b1; rx_slot_idx = 4'd0;
    #2 check("R9 spf 0 none, spf 1 slot 0", outs(), 4'b0100);
    tx_slot_idx = 4'd0; rx_slot_idx = 4'd1;
    #2 check("R9 off-by-one slots", outs(), 4'b0000);

    // R6: latched tx with enable on raises irq; R7 immediate drop on disable
    idle_cycle();
    tx_spf = 4'd4; rx_spf = 4'd3;
    tx_irq_en = 1'b1; tx_slot_vld = 1'b1; tx_slot_idx = 4'd3;
    idle_cycle();
    #2 check("R6 irq follows latched flag", outs(), 4'b1010);
    tx_irq_en = 1'b0;
    #2 check("R7 disable drops at once", outs(), 4'b0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule